// File: doc/BRIEF.md
# Multi-Channel Serial Converter Scan Controller

This block sits on the host side of a four-wire serial link to an eight-input, 12-bit sampling converter. It runs entirely in the system clock domain. It generates the converter's chip select and a serial clock divided down from the system clock. On each conversion it shifts out an eight-bit control byte that carries the next channel address, and it gathers the 16-bit word the converter returns. Starting from a channel enable mask, it visits every enabled channel in ascending order, either once per start request or continuously.

The converter answers one conversion late: the word returned during a conversion belongs to the address sent in the conversion before it. The controller keeps a record of the address the converter holds pending and tags each result with it. When the pending address at the start of a frame is not the first channel the sweep wants, the first conversion only primes the pipeline and its result is dropped. The last conversion of a sweep already sends the lowest enabled channel, so a repeated sweep over the same mask needs no priming conversion. Results leave as 12-bit data with a 3-bit channel number on a valid/ready stream. When the consumer stalls, the serial clock pauses between conversions.

Top module: `adc_scan_master`

## Requirements
- R1: After reset, chip select and serial clock are high, the serial data output is low, no result is valid and the header error flag is clear.
- R2: While chip select is high the serial clock is high. Each serial clock half period lasts `clk_div`+1 system clocks. Chip select falls at least one system clock before the first falling serial clock edge of a frame.
- R3: A conversion is exactly 16 serial clock cycles, and every chip-select-low frame holds a whole multiple of 16 rising edges.
- R4: During the first 8 cycles of each conversion the control byte goes out MSB first. It changes only after falling edges. Bits 5..3 hold the 3-bit address, where code n selects channel n, and all other bits are zero. The remaining 8 cycles drive zero.
- R5: Return data is sampled on rising edges, MSB first. The result is the low 12 bits of the 16-bit word.
- R6: Each result is tagged with the address sent during the previous conversion. After reset the pending address is channel 0.
- R7: The first conversion of a frame is discarded when the pending address differs from the lowest enabled channel. Otherwise it is delivered.
- R8: One sweep delivers each enabled channel exactly once in ascending order. Its final conversion sends the lowest enabled channel. In single mode the frame then ends.
- R9: In continuous mode chip select stays low and the scan wraps from the highest to the lowest enabled channel. Once `cont_mode` is low, the frame ends after the next completed sweep.
- R10: A start request is ignored while a frame or its trailing gap is in progress, and when the mask is all zero.
- R11: While a result waits with `res_ready` low, its channel and data stay unchanged. The engine stops with the serial clock high and chip select low before it would overwrite the result.
- R12: `hdr_err` sets when any returned word has a non-zero upper 4 bits, and it stays set until reset.
- R13: The enable mask is captured at start. Later changes do not affect the running sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a frame |
| cont_mode | input | 1 | 1: keep scanning; 0: stop after the sweep |
| ch_mask | input | 8 | Channel enable mask, bit n enables channel n |
| clk_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Control byte to the converter |
| miso | input | 1 | Return data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_chan | output | 3 | Channel the result belongs to |
| res_data | output | 12 | Conversion result, straight binary |
| hdr_err | output | 1 | Sticky flag: non-zero header bits seen |

## Verification
The bench uses the default DIV_W of 8 and switches `clk_div` at run time between 1 and 3. The short half periods keep each conversion to a few dozen system clocks, so priming, back-to-back sweeps, continuous wrap-around and a stall of several hundred cycles all fit into one run. A behavioural converter model applies the one-late address pipeline and writes the channel it actually converted into the upper result bits. Every tag can therefore be compared with the data it labels.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int NCH    = 8;
  localparam int CH_W   = 3;
  localparam int WORD_W = 16;
  localparam int RES_W  = 12;
  localparam int CTRL_W = 8;
  localparam int ADDR_LSB = 3;

  typedef logic [CH_W-1:0] ch_t;
  typedef enum logic [2:0] {SQ_IDLE, SQ_LAUNCH, SQ_BUSY, SQ_POST, SQ_GAP} sq_state_t;

  function automatic ch_t lowest_ch(input logic [NCH-1:0] m);
    ch_t r = '0;
    for (int i = NCH-1; i >= 0; i--) if (m[i]) r = ch_t'(i);
    return r;
  endfunction

  function automatic ch_t highest_ch(input logic [NCH-1:0] m);
    ch_t r = '0;
    for (int i = 0; i < NCH; i++) if (m[i]) r = ch_t'(i);
    return r;
  endfunction

  // smallest enabled channel above cur, else wrap to the lowest one
  function automatic ch_t next_ch(input logic [NCH-1:0] m, input ch_t cur);
    ch_t r = lowest_ch(m);
    for (int i = NCH-1; i >= 0; i--) if (m[i] && (i > int'(cur))) r = ch_t'(i);
    return r;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_byte(input ch_t a);
    logic [CTRL_W-1:0] b = '0;
    b[ADDR_LSB +: CH_W] = a;
    return b;
  endfunction

  function automatic logic [RES_W-1:0] result_of(input logic [WORD_W-1:0] w);
    return w[RES_W-1:0];
  endfunction

  function automatic logic header_bad(input logic [WORD_W-1:0] w);
    return |w[WORD_W-1:RES_W];
  endfunction
endpackage

// File: rtl/adc_scan_tick.sv
module adc_scan_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == div);
endmodule

// File: rtl/adc_scan_shift.sv
module adc_scan_shift
  import adc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CTRL_W-1:0] tx,
  input  logic              tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic              rise_evt,
  output logic [WORD_W-1:0] rx
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [CTRL_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;
  logic [CNT_W-1:0]  bit_cnt;
  logic              sclk_q, mosi_q, busy_q, done_q;

  assign rise_evt = busy_q && tick && !sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1; mosi_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; bit_cnt <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        busy_q  <= 1'b1;
        tx_sh   <= tx;
        bit_cnt <= '0;
        sclk_q  <= 1'b1;
      end else if (busy_q && tick) begin
        if (sclk_q) begin
          sclk_q <= 1'b0;
          mosi_q <= tx_sh[CTRL_W-1];
          tx_sh  <= {tx_sh[CTRL_W-2:0], 1'b0};
        end else begin
          sclk_q  <= 1'b1;
          rx_sh   <= {rx_sh[WORD_W-2:0], miso};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(WORD_W - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sclk = sclk_q;
  assign mosi = mosi_q;
  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_sh;

  AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(mosi_q)); // R4
  AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q); // R10
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cont_mode,
  input  logic [NCH-1:0]    ch_mask,
  input  logic              shift_done,
  input  logic              shift_busy,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              tick,
  input  logic              res_ready,
  output logic              cs_n,
  output logic              go,
  output logic [CTRL_W-1:0] tx_byte,
  output logic              gap_en,
  output logic              res_valid,
  output ch_t               res_chan,
  output logic [RES_W-1:0]  res_data,
  output logic              hdr_err
);
  sq_state_t        st;
  logic [NCH-1:0]   mask_q;
  ch_t              pend, want, tag_q;
  logic             keep_q, last_q, cs_q, val_q, err_q;
  ch_t              chan_q;
  logic [RES_W-1:0] data_q;

  logic keep_now, slot_free, post_block, emit;
  ch_t  send;

  assign keep_now   = (pend == want);
  assign send       = keep_now ? next_ch(mask_q, want) : want;
  assign go         = (st == SQ_LAUNCH);
  assign tx_byte    = ctrl_byte(send);
  assign gap_en     = (st == SQ_GAP);
  assign slot_free  = !val_q || res_ready;
  assign post_block = keep_q && !slot_free;
  assign emit       = (st == SQ_POST) && keep_q && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; mask_q <= '0; pend <= '0; want <= '0; tag_q <= '0;
      keep_q <= 1'b0; last_q <= 1'b0; cs_q <= 1'b1; val_q <= 1'b0;
      err_q <= 1'b0; chan_q <= '0; data_q <= '0;
    end else begin
      if (val_q && res_ready) val_q <= 1'b0;
      case (st)
        SQ_IDLE: if (start && |ch_mask) begin
          mask_q <= ch_mask;
          want   <= lowest_ch(ch_mask);
          cs_q   <= 1'b0;
          st     <= SQ_LAUNCH;
        end
        SQ_LAUNCH: begin
          keep_q <= keep_now;
          tag_q  <= pend;
          last_q <= keep_now && (want == highest_ch(mask_q));
          pend   <= send;
          if (keep_now) want <= next_ch(mask_q, want);
          st <= SQ_BUSY;
        end
        SQ_BUSY: if (shift_done) begin
          if (header_bad(rx_word)) err_q <= 1'b1;
          st <= SQ_POST;
        end
        SQ_POST: if (!post_block) begin
          if (emit) begin
            val_q  <= 1'b1;
            chan_q <= tag_q;
            data_q <= result_of(rx_word);
          end
          if (last_q && !cont_mode) begin
            cs_q <= 1'b1;
            st   <= SQ_GAP;
          end else begin
            st <= SQ_LAUNCH;
          end
        end
        SQ_GAP: if (tick) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign cs_n      = cs_q;
  assign res_valid = val_q;
  assign res_chan  = chan_q;
  assign res_data  = data_q;
  assign hdr_err   = err_q;

  AST_EMIT_ENABLED_CH: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> mask_q[tag_q]); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    val_q && !res_ready |=> val_q && $stable(data_q) && $stable(chan_q)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R12
  AST_FRAME_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> !shift_busy); // R3
endmodule

// File: rtl/adc_scan_master.sv
module adc_scan_master
  import adc_scan_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cont_mode,
  input  logic [7:0]       ch_mask,
  input  logic [DIV_W-1:0] clk_div,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [2:0]       res_chan,
  output logic [11:0]      res_data,
  output logic             hdr_err
);
  localparam int MOD_W = $clog2(WORD_W);

  logic              tick, go, busy, done, rise_evt, gap_en;
  logic [CTRL_W-1:0] tx_byte;
  logic [WORD_W-1:0] rx_word;

  adc_scan_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .en(busy || gap_en), .div(clk_div), .tick(tick));

  adc_scan_shift shift_i (
    .clk(clk), .rst_n(rst_n), .go(go), .tx(tx_byte), .tick(tick), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(busy), .done(done), .rise_evt(rise_evt),
    .rx(rx_word));

  adc_scan_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_mode(cont_mode),
    .ch_mask(ch_mask), .shift_done(done), .shift_busy(busy), .rx_word(rx_word),
    .tick(tick), .res_ready(res_ready), .cs_n(cs_n), .go(go), .tx_byte(tx_byte),
    .gap_en(gap_en), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .hdr_err(hdr_err));

  // rising edges modulo one conversion, kept for the frame-length check
  logic [MOD_W-1:0] rise_mod;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rise_mod <= '0;
    else if (rise_evt) rise_mod <= rise_mod + 1'b1;
  end

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk); // R2
  AST_WHOLE_CONVERSIONS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_mod == '0)); // R3
  AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> $past(tick)); // R2
endmodule

// File: tb/adc_scan_master_tb_top.sv
`timescale 1ns/1ps
module adc_scan_master_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, cont_mode, res_ready, miso, inject;
  logic [7:0] ch_mask, clk_div;
  logic cs_n, sclk, mosi, res_valid, hdr_err;
  logic [2:0] res_chan;
  logic [11:0] res_data;

  adc_scan_master dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_mode(cont_mode),
    .ch_mask(ch_mask), .clk_div(clk_div), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data), .hdr_err(hdr_err));

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---- behavioural converter: address pipeline one conversion deep ----
  int s_fall_k = 0, s_rise_k = 0, conv_total = 0, bad_ctrl = 0, frame_rises = 0;
  logic [2:0]  s_pend = 3'd0, s_conv = 3'd0, s_next = 3'd0;
  logic [7:0]  s_rx = 8'd0;
  logic [15:0] s_word = 16'd0;
  logic [8:0]  serial = 9'd0;

  always @(negedge cs_n) begin s_fall_k = 0; s_rise_k = 0; frame_rises = 0; end

  always @(negedge sclk) if (!cs_n) begin
    if (s_fall_k % 16 == 0) begin
      s_conv = s_pend;
      serial = serial + 9'd1;
      s_word = {(inject ? 4'hA : 4'h0), s_conv, serial};
      conv_total++;
    end
    miso = s_word[15 - (s_fall_k % 16)];
    s_fall_k++;
  end

  always @(posedge sclk) if (!cs_n) begin
    s_rx = {s_rx[6:0], mosi};
    s_rise_k++;
    frame_rises++;
    if (s_rise_k % 16 == 8) begin
      s_next = s_rx[5:3];
      if (s_rx[7:6] != 2'b0 || s_rx[2:0] != 3'b0) bad_ctrl++;
    end
    if (s_rise_k % 16 == 0) s_pend = s_next;
  end

  // ---- monitors ----
  int cs_rises = 0;
  always @(posedge cs_n) if (rst_n === 1'b1) begin
    cs_rises++;
    check(frame_rises % 16 == 0, "R3 frame rising edges mod 16", frame_rises % 16, 0);
  end

  realtime cs_fall_t = 0;
  realtime lead_min = 1.0e9;
  bit first_fall = 1'b0;
  always @(negedge cs_n) begin cs_fall_t = $realtime; first_fall = 1'b1; end
  always @(negedge sclk) if (!cs_n && first_fall) begin
    first_fall = 1'b0;
    if ($realtime - cs_fall_t < lead_min) lead_min = $realtime - cs_fall_t;
  end

  int low_run = 0, low_min = 1000, low_max = 0;
  int got_n = 0;
  int got_ch [64];
  int got_dat[64];
  always @(negedge clk) begin
    if (!cs_n && sclk == 1'b0) low_run++;
    else if (low_run > 0) begin
      if (low_run < low_min) low_min = low_run;
      if (low_run > low_max) low_max = low_run;
      low_run = 0;
    end
    if (res_valid && res_ready && got_n < 64) begin
      got_ch[got_n]  = int'(res_chan);
      got_dat[got_n] = int'(res_data);
      got_n++;
    end
  end

  // ---- helpers ----
  task automatic clear_log();
    got_n = 0; conv_total = 0; low_min = 1000; low_max = 0; cs_rises = 0;
  endtask

  task automatic start_sweep(input logic [7:0] m, input logic cont, input logic [7:0] dv);
    @(posedge clk); #1;
    ch_mask = m; cont_mode = cont; clk_div = dv; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_frame(input string req);
    int t = 0;
    while (cs_n && t < 5000) begin @(negedge clk); t++; end
    while (!cs_n && t < 60000) begin @(negedge clk); t++; end
    if (t >= 60000) check(1'b0, req, t, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic check_sweep(input logic [7:0] m, input int s0, input int off);
    int exp_ch[8];
    int k = 0;
    for (int c = 0; c < 8; c++) if (m[c]) begin exp_ch[k] = c; k++; end
    check(got_n == k, "R8 result count per sweep", got_n, k);
    for (int i = 0; i < got_n && i < k; i++) begin
      check(got_ch[i] == exp_ch[i], "R8 ascending channel order", got_ch[i], exp_ch[i]);
      check((got_dat[i] >> 9) == got_ch[i], "R6 tag matches converted channel",
            got_dat[i] >> 9, got_ch[i]);
      check((got_dat[i] & 511) == (s0 + off + i) % 512, "R5 12-bit data",
            got_dat[i] & 511, (s0 + off + i) % 512);
    end
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    check(cs_n == 1'b1, "R1 cs_n after reset", int'(cs_n), 1);
    check(sclk == 1'b1, "R1 sclk after reset", int'(sclk), 1);
    check(mosi == 1'b0, "R1 mosi after reset", int'(mosi), 0);
    check(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    check(hdr_err == 1'b0, "R1 hdr_err after reset", int'(hdr_err), 0);
  endtask

  task automatic t_single_primed();
    int s0;
    clear_log(); s0 = int'(serial);
    start_sweep(8'hA6, 1'b0, 8'd1);
    wait_frame("R8 single sweep timeout");
    check(conv_total == 5, "R7 priming conversion added", conv_total, 5);
    check_sweep(8'hA6, s0, 2);
    check(low_min == 2 && low_max == 2, "R2 half period div=1", low_max, 2);
    check(lead_min >= 5.0, "R2 cs_n lead before first fall", int'(lead_min), 5);
    check(bad_ctrl == 0, "R4 control byte spare bits", bad_ctrl, 0);
    check(cs_rises == 1, "R8 single sweep ends frame", cs_rises, 1);
  endtask

  task automatic t_single_repeat();
    int s0;
    clear_log(); s0 = int'(serial);
    start_sweep(8'hA6, 1'b0, 8'd1);
    wait_frame("R7 repeat sweep timeout");
    check(conv_total == 4, "R7 no priming when pending matches", conv_total, 4);
    check_sweep(8'hA6, s0, 1);
  endtask

  task automatic t_continuous();
    int t = 0;
    bit alt_ok = 1'b1;
    clear_log();
    start_sweep(8'h09, 1'b1, 8'd1);
    while (got_n < 6 && t < 20000) begin @(negedge clk); t++; end
    check(cs_n == 1'b0 && cs_rises == 0, "R9 cs_n held low while scanning", cs_rises, 0);
    @(posedge clk); #1; cont_mode = 1'b0;
    wait_frame("R9 continuous stop timeout");
    for (int i = 0; i < got_n; i++)
      if (got_ch[i] != ((i % 2 == 0) ? 0 : 3)) alt_ok = 1'b0;
    check(alt_ok, "R9 wrap order 0,3,0,3", got_ch[1], 3);
    check(got_n >= 6 && got_n % 2 == 0, "R9 ends on completed sweep", got_n, 6);
    check(cs_rises == 1, "R9 single frame", cs_rises, 1);
  endtask

  task automatic t_backpressure();
    int t = 0;
    int d0, c0, cv1, r1;
    clear_log();
    res_ready = 1'b0;
    start_sweep(8'h70, 1'b0, 8'd1);
    while (!res_valid && t < 5000) begin @(negedge clk); t++; end
    d0 = int'(res_data); c0 = int'(res_chan);
    repeat (150) @(negedge clk);
    cv1 = conv_total; r1 = frame_rises;
    repeat (200) @(negedge clk);
    check(res_valid == 1'b1, "R11 result held while not ready", int'(res_valid), 1);
    check(int'(res_data) == d0 && int'(res_chan) == c0, "R11 result stable", int'(res_data), d0);
    check(conv_total == cv1 && frame_rises == r1, "R11 engine paused", frame_rises, r1);
    check(sclk == 1'b1 && cs_n == 1'b0, "R11 pause with sclk high, cs low", int'(sclk), 1);
    @(posedge clk); #1; res_ready = 1'b1;
    wait_frame("R11 resume timeout");
    check(c0 == 4, "R11 first held channel", c0, 4);
    check(got_n == 3 && got_ch[0] == 4 && got_ch[1] == 5 && got_ch[2] == 6,
          "R11 all results delivered in order", got_n, 3);
  endtask

  task automatic t_ignore_and_latch();
    int cv;
    clear_log();
    start_sweep(8'hC0, 1'b0, 8'd1);
    repeat (30) @(negedge clk);
    start_sweep(8'h01, 1'b0, 8'd1);
    wait_frame("R13 latch sweep timeout");
    check(got_n == 2, "R10 busy start ignored", got_n, 2);
    check(got_ch[0] == 6 && got_ch[1] == 7, "R13 mask captured at start", got_ch[0], 6);
    cv = conv_total;
    start_sweep(8'h00, 1'b0, 8'd1);
    repeat (100) @(negedge clk);
    check(cs_n == 1'b1 && conv_total == cv, "R10 empty mask ignored", conv_total, cv);
  endtask

  task automatic t_divider();
    clear_log();
    start_sweep(8'h80, 1'b0, 8'd3);
    wait_frame("R2 divider sweep timeout");
    check(low_min == 4 && low_max == 4, "R2 half period div=3", low_max, 4);
    check(got_n == 1 && got_ch[0] == 7, "R8 single channel sweep", got_ch[0], 7);
  endtask

  task automatic t_header();
    check(hdr_err == 1'b0, "R12 flag clear before fault", int'(hdr_err), 0);
    clear_log();
    inject = 1'b1;
    start_sweep(8'h01, 1'b0, 8'd1);
    wait_frame("R12 header sweep timeout");
    inject = 1'b0;
    check(hdr_err == 1'b1, "R12 flag set on bad header", int'(hdr_err), 1);
    check(got_n == 1 && (got_dat[0] >> 9) == 0, "R5 header bits stripped", got_dat[0] >> 9, 0);
    repeat (50) @(negedge clk);
    check(hdr_err == 1'b1, "R12 flag sticky", int'(hdr_err), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cont_mode = 1'b0; res_ready = 1'b1;
    ch_mask = 8'h00; clk_div = 8'd1; miso = 1'b0; inject = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single_primed();
    t_single_repeat();
    t_continuous();
    t_backpressure();
    t_ignore_and_latch();
    t_divider();
    t_header();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule